// File: doc/BRIEF.md
# PWM Channel with Clock Bypass

This block drives one pulse-width-modulated output pin from its own clock. A control word selects a prescaler divisor, the output polarity and whether the channel runs. A timing word gives the period and the active-duty length, both counted in prescaled ticks. While the channel runs, every period starts with the duty portion at the active level and ends with the rest at the inactive level. Period and duty values written during a run take effect only at the next period boundary, so a change never cuts a pulse short or stretches it.

A bypass bit overrides everything else. The block's clock then passes unchanged to the pin, which gives the highest frequency the channel can produce. A two-bit mode output reports the effective state: off, running, bypassed, or stalled on an unusable divisor.

Settings are loaded through a single write strobe with a one-bit register select.

Top module: `pwm_bypass_chan`

## Requirements
- R1: After reset the control word holds only the active-high bit (value 0x40). `pwm_o` is low and `mode_o` is 0.
- R2: The control word is `wr_data[7:0]` when `wr_addr`=0. The fields are prescaler code in bits 3:0, enable in bit 4, clock-gate in bit 5, active-high in bit 6 and bypass in bit 7.
- R3: The timing word is written when `wr_addr`=1. The period count is in `wr_data[15:0]` and the duty count is in `wr_data[31:16]`, both in prescaled ticks.
- R4: The channel counts only while both the gate bit and the enable bit are 1. With either bit 0, the output holds the inactive level and the counter is held at the start of a period.
- R5: While the channel runs with period P and duty D, each period of P ticks is active for its first D ticks. If D is at least P, the output stays active. If D is 0, the output stays inactive.
- R6: With active-high set to 1, the active level is high. With it set to 0, the output is inverted, so the active level is low and the idle level is high.
- R7: Prescaler codes 0 to 15 divide by 120, 180, 240, 360, 480, 0, 0, 0, 12000, 24000, 36000, 48000, 72000, 0, 0 and 1 respectively. Code 15 divides by one when direct division is enabled.
- R8: A code whose divisor is 0 produces no pulses. The output holds the inactive level and `mode_o` reads 3.
- R9: A timing word written while the channel runs is applied only at the end of the current period. Every pulse therefore has either the old duty length or the new one.
- R10: While bypass is 1, `pwm_o` equals `clk` from the cycle after the write, whatever the enable, gate, polarity and code settings. Clearing bypass restarts PWM output from a fresh period.
- R11: `mode_o` reads 0 when off, 1 when running, 2 when bypassed and 3 when stalled. Bypass takes precedence over all the other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and PWM source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the timing word |
| wr_data | input | 32 | Write data |
| pwm_o | output | 1 | PWM output pin |
| mode_o | output | 2 | Effective mode |

## Verification
The risky coincidence is a timing-word write that lands on the same edge as the end of a period, because the shadow load and the counter wrap then share one cycle. The bench provokes it by rewriting the duty between 5 and 2 on a period of 10, with delays stepped so that the writes fall on every phase of the period, including the wrap edge. Every completed high pulse is then measured, and any length other than 2 or 5 is a failure. A second coincidence is bypass being set or cleared in the middle of a period. It is judged by sampling the pin in both clock phases and by checking the duty of the first periods that follow.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_RUN    = 2'd1,
    MODE_BYPASS = 2'd2,
    MODE_STALL  = 2'd3
  } mode_e;

  // bit 7 bypass, 6 active-high, 5 gate, 4 enable, 3:0 prescaler code
  typedef struct packed {
    logic       bypass;
    logic       act_high;
    logic       gate;
    logic       enable;
    logic [3:0] psel;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h40;

  function automatic logic [31:0] presc_div(input logic [3:0] code,
                                            input logic direct_ok);
    case (code)
      4'd0:    return 32'd120;
      4'd1:    return 32'd180;
      4'd2:    return 32'd240;
      4'd3:    return 32'd360;
      4'd4:    return 32'd480;
      4'd8:    return 32'd12000;
      4'd9:    return 32'd24000;
      4'd10:   return 32'd36000;
      4'd11:   return 32'd48000;
      4'd12:   return 32'd72000;
      4'd15:   return direct_ok ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [2*CNT_W-1:0] wr_data,
  output ctrl_t              ctrl_q,
  output logic [CNT_W-1:0]   per_q,
  output logic [CNT_W-1:0]   duty_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      per_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      if (!wr_addr) begin
        ctrl_q <= ctrl_t'(wr_data[7:0]);
      end else begin
        per_q  <= wr_data[CNT_W-1:0];
        duty_q <= wr_data[2*CNT_W-1:CNT_W];
      end
    end
  end

endmodule

// File: rtl/pwm_chan_presc.sv
module pwm_chan_presc
  import pwm_chan_pkg::*;
#(
  parameter int PRE_W     = 17,
  parameter bit DIRECT_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic [3:0] psel_i,
  output logic       tick_o,
  output logic       valid_o
);

  logic [PRE_W-1:0] div_w;
  logic [PRE_W-1:0] pre_cnt;
  logic             last_w;

  assign div_w   = PRE_W'(presc_div(psel_i, DIRECT_OK));
  assign valid_o = (div_w != '0);
  assign last_w  = (pre_cnt >= div_w - PRE_W'(1));
  assign tick_o  = run_i && valid_o && last_w;

  always_ff @(posedge clk) begin
    if (rst || !run_i || !valid_o) pre_cnt <= '0;
    else if (last_w)               pre_cnt <= '0;
    else                           pre_cnt <= pre_cnt + PRE_W'(1);
  end

  // R7
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (pre_cnt == '0));

endmodule

// File: rtl/pwm_chan_count.sv
module pwm_chan_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             act_high_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             level_o
);

  logic [CNT_W-1:0] per_cur, duty_cur, cnt;
  logic             end_w, load_w, active_w;

  assign end_w    = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, per_cur};
  assign load_w   = !run_i || (tick_i && end_w);
  assign active_w = (duty_cur != '0) && ((duty_cur >= per_cur) || (cnt < duty_cur));

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cur  <= '0;
      duty_cur <= '0;
      cnt      <= '0;
      level_o  <= 1'b0;
    end else begin
      if (load_w) begin
        per_cur  <= per_i;
        duty_cur <= duty_i;
      end
      if (!run_i)               cnt <= '0;
      else if (tick_i && end_w) cnt <= '0;
      else if (tick_i)          cnt <= cnt + CNT_W'(1);
      level_o <= (run_i && active_w) ? act_high_i : !act_high_i;
    end
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !(tick_i && end_w)) |=> ($stable(per_cur) && $stable(duty_cur)));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (level_o == !$past(act_high_i)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && per_cur != '0) |-> (cnt < per_cur));

endmodule

// File: rtl/pwm_bypass_chan.sv
module pwm_bypass_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_W     = 17,
  parameter bit DIRECT_OK = 1'b1,
  localparam int DATA_W   = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_o,
  output logic [1:0]        mode_o
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_q, duty_q;
  logic             want_run, tick, div_ok, run_w, level_q;
  mode_e            mode_w;

  pwm_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .per_q(per_q), .duty_q(duty_q)
  );

  assign want_run = ctrl_q.gate && ctrl_q.enable && !ctrl_q.bypass;
  assign run_w    = want_run && div_ok;

  pwm_chan_presc #(.PRE_W(PRE_W), .DIRECT_OK(DIRECT_OK)) u_presc (
    .clk(clk), .rst(rst), .run_i(want_run), .psel_i(ctrl_q.psel),
    .tick_o(tick), .valid_o(div_ok)
  );

  pwm_chan_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run_i(run_w), .tick_i(tick),
    .act_high_i(ctrl_q.act_high), .per_i(per_q), .duty_i(duty_q),
    .level_o(level_q)
  );

  always_comb begin
    if (ctrl_q.bypass)                      mode_w = MODE_BYPASS;
    else if (ctrl_q.gate && ctrl_q.enable)  mode_w = div_ok ? MODE_RUN : MODE_STALL;
    else                                    mode_w = MODE_OFF;
  end

  assign mode_o = mode_w;
  assign pwm_o  = ctrl_q.bypass ? clk : level_q;

endmodule

// File: tb/pwm_bypass_chan_bench.sv
`timescale 1ns/1ps
module pwm_bypass_chan_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pwm_o;
  logic [1:0]  mode_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pwm_bypass_chan u_pwm_bypass_chan (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o), .mode_o(mode_o)
  );

  // {code[4], act_high[1], period[8], duty[8], expected high samples[16]}
  localparam int NV = 8;
  localparam logic [36:0] VEC [0:NV-1] = '{
    {4'd15, 1'b1, 8'd8, 8'd3,  16'd12},
    {4'd15, 1'b1, 8'd8, 8'd0,  16'd0},
    {4'd15, 1'b1, 8'd8, 8'd8,  16'd32},
    {4'd15, 1'b1, 8'd8, 8'd20, 16'd32},
    {4'd15, 1'b0, 8'd8, 8'd3,  16'd20},
    {4'd15, 1'b1, 8'd5, 8'd1,  16'd4},
    {4'd0,  1'b1, 8'd4, 8'd1,  16'd480},
    {4'd1,  1'b0, 8'd3, 8'd2,  16'd720}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit byp, input bit pol, input bit gate,
                                      input bit en, input logic [3:0] code);
    return {24'd0, byp, pol, gate, en, code};
  endfunction

  function automatic int bdiv(input logic [3:0] code);
    case (code)
      4'd0: return 120;
      4'd1: return 180;
      default: return 1;
    endcase
  endfunction

  task automatic measure(input int cycles, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0; prev = pwm_o;
    repeat (cycles) begin
      @(negedge clk);
      if (pwm_o) hi++;
      if (pwm_o && !prev) rises++;
      prev = pwm_o;
    end
  endtask

  // pulse-length tracker for the shadow-load test
  bit track = 0;
  int run_len = 0, nruns = 0, badruns = 0;
  bit first_run = 1;
  always @(negedge clk) begin
    if (track) begin
      if (pwm_o) run_len++;
      else if (run_len != 0) begin
        if (!first_run) begin
          nruns++;
          if (run_len != 2 && run_len != 5) begin
            badruns++;
            $display("FAIL R9 pulse length actual=%0d expected=2 or 5", run_len);
          end
        end
        first_run = 0;
        run_len = 0;
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, rises;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pwm_o == 1'b0, "R1 reset pwm_o", pwm_o, 0);
    check(mode_o == 2'd0, "R1 reset mode", mode_o, 0);

    // table-driven duty / polarity / prescaler sweep
    for (int i = 0; i < NV; i++) begin
      logic [3:0] code; logic pol; int per, duty, exph, dv; string req;
      code = VEC[i][36:33]; pol = VEC[i][32];
      per = VEC[i][31:24]; duty = VEC[i][23:16]; exph = VEC[i][15:0];
      dv = bdiv(code);
      req = (code != 4'd15) ? "R7" : (!pol ? "R6" : "R5 R3");
      wr(1'b0, ctl(0, pol, 0, 0, code));
      wr(1'b1, {16'(duty), 16'(per)});
      wr(1'b0, ctl(0, pol, 1, 1, code));
      repeat (3 * per * dv + 4) @(negedge clk);
      check(mode_o == 2'd1, "R11 R2 run mode", mode_o, 1);
      measure(4 * per * dv, hi, rises);
      check(hi == exph, req, hi, exph);
      if (duty > 0 && duty < per) check(rises == 4, "R5 pulses per window", rises, 4);
    end

    // gate without enable, enable without gate
    wr(1'b1, {16'd3, 16'd8});
    wr(1'b0, ctl(0, 1, 1, 0, 4'd15));
    repeat (4) @(negedge clk);
    measure(32, hi, rises);
    check(hi == 0, "R4 gate only", hi, 0);
    check(mode_o == 2'd0, "R11 off mode", mode_o, 0);
    wr(1'b0, ctl(0, 0, 0, 1, 4'd15));
    repeat (4) @(negedge clk);
    measure(32, hi, rises);
    check(hi == 32, "R4 enable only inverted idle", hi, 32);

    // zero divisor codes
    wr(1'b0, ctl(0, 1, 1, 1, 4'd5));
    repeat (4) @(negedge clk);
    measure(64, hi, rises);
    check(hi == 0, "R8 code 5 no pulses", hi, 0);
    check(mode_o == 2'd3, "R8 stall mode", mode_o, 3);
    wr(1'b0, ctl(0, 0, 1, 1, 4'd14));
    repeat (4) @(negedge clk);
    measure(64, hi, rises);
    check(hi == 64, "R8 code 14 inverted idle", hi, 64);

    // bypass over a running channel, then over a disabled inverted one
    wr(1'b0, ctl(0, 1, 1, 1, 4'd15));
    repeat (5) @(negedge clk);
    wr(1'b0, ctl(1, 1, 1, 1, 4'd15));
    check(mode_o == 2'd2, "R11 bypass mode", mode_o, 2);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check(pwm_o == 1'b1, "R10 high phase", pwm_o, 1);
      @(negedge clk); #1;
      check(pwm_o == 1'b0, "R10 low phase", pwm_o, 0);
    end
    wr(1'b0, ctl(1, 0, 0, 0, 4'd5));
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(pwm_o == 1'b1, "R10 ignore settings high", pwm_o, 1);
      @(negedge clk); #1;
      check(pwm_o == 1'b0, "R10 ignore settings low", pwm_o, 0);
    end
    check(mode_o == 2'd2, "R11 bypass precedence", mode_o, 2);
    wr(1'b0, ctl(0, 1, 1, 1, 4'd15));
    @(negedge clk);
    measure(32, hi, rises);
    check(hi == 12, "R10 resume after bypass", hi, 12);

    // shadow load under writes on every period phase
    wr(1'b1, {16'd5, 16'd10});
    repeat (25) @(negedge clk);
    track = 1;
    for (int k = 0; k < 20; k++) begin
      wr(1'b1, {((k % 2) != 0) ? 16'd5 : 16'd2, 16'd10});
      repeat ((k * 3) % 10 + 1) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    track = 0;
    check(badruns == 0, "R9 pulse lengths", badruns, 0);
    check(nruns >= 5, "R9 pulses seen", nruns, 5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule